// File: doc/BRIEF.md
# Serial Transceiver with Build-Time Parity

This block is an asynchronous serial transmitter and receiver pair behind a small register window. Software writes a character to the transmit register, and the transmitter shifts it out on `txd`. The frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop bit. The line rests high between frames. Each bit lasts `16*OVS_DIV` clock cycles. The receiver passes `rxd` through a synchronizer chain that is `SYNC_STAGES` flops long; each added stage delays reception by one cycle. It samples the line with a 16x oversampling tick and reads each bit at its midpoint. The received character and a parity verdict land in a holding register that software reads.

The parity mode is fixed when the block is built: none, even or odd. Even parity makes the parity bit 1 exactly when the character holds an odd number of ones. Odd parity makes it 1 exactly when the character holds an even number of ones. With no parity the frame carries no parity bit in either direction, and the parity-error flag does not exist (it reads 0). The register port is plain control: a write or read takes effect in the single cycle its enable is high and applies no back-pressure. A write that the transmitter cannot take is dropped, and software is expected to poll the ready bit first.

Top module: `uart_par_top`

## Requirements
- R1: After reset `txd` is 1 and the status register reads transmit-ready 1, receive-ready 0 and parity-error 0.
- R2: A write to address 0 while transmit-ready is 1 starts a frame on the following cycle. The frame is a start bit 0, the DATA_W data bits least significant bit first, the parity bit when enabled, and a stop bit 1, each held for 16*OVS_DIV cycles. Transmit-ready is 0 from the cycle after the write until the frame ends.
- R3: In even mode the transmitted parity bit is the XOR of the data bits (1 when the count of ones is odd).
- R4: In odd mode the transmitted parity bit is the inverse of the XOR of the data bits (0 when the count of ones is odd).
- R5: In none mode the frame has no parity bit, and the stop bit follows the last data bit directly.
- R6: A write to address 0 while transmit-ready is 0 is ignored; the frame in progress continues unchanged.
- R7: A read of address 2 returns status with bit 0 = transmit-ready, bit 1 = receive-ready, bit 2 = parity-error, and the other bits 0.
- R8: A received frame places its data in the receive register, which is read at address 1, and sets receive-ready. A read of address 1 clears receive-ready.
- R9: In even or odd mode, a frame whose parity bit does not match its data sets parity-error. The flag stays set through later good frames until any write to address 2 clears it.
- R10: In none mode parity-error always reads 0.
- R11: A low pulse on `rxd` that ends before the middle of the start bit is rejected, and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect: clears receive-ready at address 1) |
| addr | input | 2 | Register address: 0 transmit, 1 receive, 2 status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the same cycle as `addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The transmitter's shift state is visible on `txd` at every cycle. A wrong bit order, a wrong parity formula or an off-by-one bit length shows up as a mismatch against the bench's model within one bit time of the fault. A wrong receive state machine does not appear at the ports until the end of the frame, when the status and receive registers are read. An incorrect sample point, a wrong parity judgement or a missing glitch rejection therefore shows up within one frame plus a few synchronizer cycles. The bench runs all three parity builds side by side on the same register traffic, so a fault that affects only one mode stands out against the other two.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } par_mode_e;

  typedef enum logic [1:0] {
    RXS_IDLE  = 2'd0,
    RXS_START = 2'd1,
    RXS_BITS  = 2'd2
  } rx_state_e;

  localparam int OVS = 16;

  localparam logic [1:0] ADDR_TX   = 2'd0;
  localparam logic [1:0] ADDR_RX   = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/uart_par_sync.sv
module uart_par_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
  import uart_par_pkg::*;
#(
  parameter int        DATA_W  = 8,
  parameter int        OVS_DIV = 2,
  parameter par_mode_e PARITY  = PAR_EVEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ldata,
  output logic              txd,
  output logic              busy
);
  localparam int PBITS   = (PARITY == PAR_NONE) ? 0 : 1;
  localparam int FRAME_W = DATA_W + PBITS + 2;
  localparam int BIT_CLK = OVS * OVS_DIV;
  localparam int CW      = $clog2(BIT_CLK);
  localparam int IW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] frame;
  logic [CW-1:0]      cnt;
  logic [IW-1:0]      idx;
  logic               bit_end;

  generate
    if (PBITS == 1) begin : g_par
      logic pbit;
      assign pbit  = (PARITY == PAR_ODD) ? ~(^ldata) : (^ldata);
      assign frame = {1'b1, pbit, ldata, 1'b0};
    end else begin : g_nopar
      assign frame = {1'b1, ldata, 1'b0};
    end
  endgenerate

  assign bit_end = (cnt == CW'(BIT_CLK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      cnt  <= '0;
      idx  <= '0;
    end else if (busy) begin
      if (bit_end) begin
        cnt <= '0;
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        if (idx == IW'(FRAME_W - 1)) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (load) begin
      busy <= 1'b1;
      sh   <= frame;
      cnt  <= '0;
      idx  <= '0;
    end
  end

  assign txd = busy ? sh[0] : 1'b1;

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> $stable(txd));

  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !bit_end) |=> $stable(sh));

endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx
  import uart_par_pkg::*;
#(
  parameter int        DATA_W  = 8,
  parameter int        OVS_DIV = 2,
  parameter par_mode_e PARITY  = PAR_EVEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxs,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              par_bad
);
  localparam int PBITS = (PARITY == PAR_NONE) ? 0 : 1;
  localparam int NB    = DATA_W + PBITS + 1;
  localparam int IW    = $clog2(NB + 1);
  localparam int DW    = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;

  rx_state_e        state;
  logic [DW-1:0]    div;
  logic             tick;
  logic [3:0]       cnt;
  logic [IW-1:0]    idx;
  logic [NB-1:0]    sh;
  logic [NB-1:0]    nv;
  logic             exp_par;

  assign tick = (div == DW'(OVS_DIV - 1));
  assign nv   = {rxs, sh[NB-1:1]};
  assign exp_par = (PARITY == PAR_ODD) ? ~(^nv[DATA_W-1:0]) : (^nv[DATA_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else        div <= tick ? '0 : div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RXS_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      par_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          RXS_IDLE: begin
            if (!rxs) begin
              state <= RXS_START;
              cnt   <= '0;
            end
          end
          RXS_START: begin
            if (cnt == 4'd7) begin
              cnt <= '0;
              idx <= '0;
              state <= rxs ? RXS_IDLE : RXS_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RXS_BITS: begin
            if (cnt == 4'd15) begin
              cnt <= '0;
              sh  <= nv;
              if (idx == IW'(NB - 1)) begin
                state   <= RXS_IDLE;
                done    <= 1'b1;
                rdata   <= nv[DATA_W-1:0];
                par_bad <= (PBITS == 1) ? (nv[DATA_W] != exp_par) : 1'b0;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RXS_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_reject_glitch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RXS_START && tick && cnt == 4'd7 && rxs) |=> (state == RXS_IDLE));

endmodule

// File: rtl/uart_par_top.sv
module uart_par_top
  import uart_par_pkg::*;
#(
  parameter int        DATA_W      = 8,
  parameter int        OVS_DIV     = 2,
  parameter int        SYNC_STAGES = 2,
  parameter par_mode_e PARITY      = PAR_EVEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rxd,
  output logic              txd
);
  logic              rxs;
  logic              tx_busy;
  logic              rx_done;
  logic [DATA_W-1:0] rx_word;
  logic              rx_bad;
  logic [DATA_W-1:0] rx_hold;
  logic              rx_ready;
  logic              perr;
  logic              tx_load;
  logic              rd_rx;
  logic              wr_stat;

  assign tx_load = wr_en && (addr == ADDR_TX);
  assign rd_rx   = rd_en && (addr == ADDR_RX);
  assign wr_stat = wr_en && (addr == ADDR_STAT);

  uart_par_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  uart_par_tx #(.DATA_W(DATA_W), .OVS_DIV(OVS_DIV), .PARITY(PARITY)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .ldata(wdata),
    .txd(txd), .busy(tx_busy)
  );

  uart_par_rx #(.DATA_W(DATA_W), .OVS_DIV(OVS_DIV), .PARITY(PARITY)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxs(rxs), .done(rx_done),
    .rdata(rx_word), .par_bad(rx_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold  <= '0;
      rx_ready <= 1'b0;
    end else if (rx_done) begin
      rx_hold  <= rx_word;
      rx_ready <= 1'b1;
    end else if (rd_rx) begin
      rx_ready <= 1'b0;
    end
  end

  generate
    if (PARITY == PAR_NONE) begin : g_noperr
      assign perr = 1'b0;
    end else begin : g_perr
      logic perr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  perr_q <= 1'b0;
        else if (rx_done && rx_bad)  perr_q <= 1'b1;
        else if (wr_stat)            perr_q <= 1'b0;
      end
      assign perr = perr_q;

      p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !wr_stat) |=> perr);

      p_perr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !rx_done) |=> !perr);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_TX:   rdata = '0;
      ADDR_RX:   rdata = rx_hold;
      ADDR_STAT: rdata = DATA_W'({perr, rx_ready, !tx_busy});
      default:   rdata = '0;
    endcase
  end

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_done) |=> !rx_ready);

  p_load_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_busy) |=> tx_busy);

endmodule

// File: tb/uart_par_top_bench.sv
module uart_par_top_bench;
  import uart_par_pkg::*;

  localparam int CLK_P   = 10;
  localparam int DATA_W  = 8;
  localparam int OVS_DIV = 2;
  localparam int BIT_CLK = 16 * OVS_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [2:0] rxd_m = 3'b111;
  logic [2:0] txd_m;
  logic [DATA_W-1:0] rdata_m [3];
  logic [DATA_W-1:0] rd_v [3];

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int m, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s mode %0d actual %0h expected %0h at %0t", req, m, act, exp, $time);
    end
  endtask

  for (genvar m = 0; m < 3; m++) begin : g_m
    uart_par_top #(.DATA_W(DATA_W), .OVS_DIV(OVS_DIV), .SYNC_STAGES(2),
                   .PARITY(par_mode_e'(m))) u_uart_par_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata_m[m]), .rxd(rxd_m[m]), .txd(txd_m[m])
    );

    // behavioural transmit model: bit list and cycle counters
    int busy, idx, cnt, nb;
    logic bits [16];

    always @(posedge clk) begin
      if (!rst_n) begin
        busy = 0; idx = 0; cnt = 0; nb = 0;
      end else if (busy != 0) begin
        cnt++;
        if (cnt == BIT_CLK) begin
          cnt = 0;
          idx++;
          if (idx == nb) busy = 0;
        end
      end else if (wr_en && addr == 2'd0) begin
        busy = 1; idx = 0; cnt = 0;
        bits[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) bits[1+i] = wdata[i];
        if (m == 0) begin
          bits[DATA_W+1] = 1'b1;
          nb = DATA_W + 2;
        end else begin
          bits[DATA_W+1] = (m == 1) ? ^wdata : ~^wdata;
          bits[DATA_W+2] = 1'b1;
          nb = DATA_W + 3;
        end
      end
    end

    always @(negedge clk) begin
      if (rst_n) begin
        if (busy != 0 && idx == DATA_W + 1)
          check((m == 0) ? "R5" : (m == 1) ? "R3" : "R4", m, int'(txd_m[m]), int'(bits[idx]));
        else if (busy != 0)
          check("R2", m, int'(txd_m[m]), int'(bits[idx]));
        else
          check("R2", m, int'(txd_m[m]), 1);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_all(input logic [1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    for (int m = 0; m < 3; m++) rd_v[m] = rdata_m[m];
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_rx(input logic [DATA_W-1:0] d, input logic flip);
    logic fr [3][12];
    int n [3];
    for (int m = 0; m < 3; m++) begin
      fr[m][0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) fr[m][1+i] = d[i];
      if (m == 0) begin
        fr[m][DATA_W+1] = 1'b1;
        n[m] = DATA_W + 2;
      end else begin
        fr[m][DATA_W+1] = ((m == 1) ? ^d : ~^d) ^ flip;
        fr[m][DATA_W+2] = 1'b1;
        n[m] = DATA_W + 3;
      end
    end
    for (int t = 0; t < DATA_W + 3; t++) begin
      for (int m = 0; m < 3; m++) rxd_m[m] = (t < n[m]) ? fr[m][t] : 1'b1;
      repeat (BIT_CLK) @(negedge clk);
    end
    rxd_m = 3'b111;
    repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  task automatic wait_frame();
    repeat ((DATA_W + 4) * BIT_CLK) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++) check("R1", m, int'(txd_m[m]), 1);
    rst_n = 1'b1;
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R1", m, int'(rd_v[m]), 32'h1);

    // transmit with an overlapping write that must be dropped (R6)
    wr(2'd0, 8'hA5);
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R7", m, int'(rd_v[m][0]), 0);
    repeat (3 * BIT_CLK) @(negedge clk);
    wr(2'd0, 8'h3C);
    wait_frame();
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R7", m, int'(rd_v[m]), 32'h1);

    // parity patterns on transmit: R3 R4 R5
    wr(2'd0, 8'h00); wait_frame();
    wr(2'd0, 8'hFF); wait_frame();
    wr(2'd0, 8'h01); wait_frame();
    wr(2'd0, 8'h07); wait_frame();

    // receive good frame: R8
    send_rx(8'h5A, 1'b0);
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R8", m, int'(rd_v[m]), 32'h3);
    rd_all(2'd1);
    for (int m = 0; m < 3; m++) check("R8", m, int'(rd_v[m]), 32'h5A);
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R8", m, int'(rd_v[m]), 32'h1);

    // receive with wrong parity: R9, R10
    send_rx(8'h13, 1'b1);
    rd_all(2'd2);
    check("R10", 0, int'(rd_v[0]), 32'h3);
    check("R9", 1, int'(rd_v[1]), 32'h7);
    check("R9", 2, int'(rd_v[2]), 32'h7);
    rd_all(2'd1);
    for (int m = 0; m < 3; m++) check("R8", m, int'(rd_v[m]), 32'h13);

    // good frame keeps the flag (sticky), status write clears it: R9
    send_rx(8'hC6, 1'b0);
    rd_all(2'd1);
    for (int m = 0; m < 3; m++) check("R8", m, int'(rd_v[m]), 32'hC6);
    rd_all(2'd2);
    check("R10", 0, int'(rd_v[0]), 32'h1);
    check("R9", 1, int'(rd_v[1]), 32'h5);
    check("R9", 2, int'(rd_v[2]), 32'h5);
    wr(2'd2, 8'h00);
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R9", m, int'(rd_v[m]), 32'h1);

    // odd number of ones received cleanly: R3 R4 on receive
    send_rx(8'h07, 1'b0);
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R9", m, int'(rd_v[m]), 32'h3);
    rd_all(2'd1);
    for (int m = 0; m < 3; m++) check("R8", m, int'(rd_v[m]), 32'h07);

    // short low glitch is rejected: R11
    @(negedge clk);
    rxd_m = 3'b000;
    repeat (BIT_CLK / 4) @(negedge clk);
    rxd_m = 3'b111;
    repeat (2 * BIT_CLK) @(negedge clk);
    rd_all(2'd2);
    for (int m = 0; m < 3; m++) check("R11", m, int'(rd_v[m]), 32'h1);

    // receiver still works after the glitch
    send_rx(8'h81, 1'b0);
    rd_all(2'd1);
    for (int m = 0; m < 3; m++) check("R11", m, int'(rd_v[m]), 32'h81);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule